// File: doc/BRIEF.md
# Windowed Conversion-Result Watchdog

This block watches a stream of already-compensated conversion results and flags any result that falls outside a programmable window. The window is defined by a low and a high bound. Each bound is written through its own write port. On each end-of-conversion strobe the accompanying data word is compared against the window. A result outside the window sets a sticky out-of-window flag and produces a one-cycle interrupt pulse. The flag stays set until an explicit clear input removes it.

The bounds may be rewritten at any time. A conversion is in flight from the cycle after its start strobe up to and including the cycle of its end strobe. A bound written while a conversion is in flight suppresses the comparison for that conversion only. The suppression is lifted at the next start strobe, so the rewritten bounds govern the conversion that begins after the update. A bound written while no conversion is in flight takes effect at once, with no suppression. Rewriting the bounds never lowers a flag that is already set.

Top module: `win_watchdog`

## Requirements
- R1: After reset `outFlag` and `irqPulse` are 0, the low bound is 0 and the high bound is all ones (0xFFF at 12 bits), so no data word is out of window.
- R2: When `eocStrobe` is high and the comparison is not suppressed, a data word strictly below the low bound or strictly above the high bound drives `irqPulse` high and sets `outFlag`, both on the clock edge that follows the `eocStrobe` cycle.
- R3: A data word equal to either bound counts as inside the window and produces no pulse and no flag.
- R4: `irqPulse` stays high for exactly one cycle for each qualifying end-of-conversion.
- R5: `outFlag` is sticky and is cleared only by `flagClr`. If a new out-of-window hit arrives in the same cycle as `flagClr`, the flag stays set.
- R6: A write to either bound in a cycle where a conversion is in flight suppresses that conversion's comparison, and no pulse or flag results. A conversion is in flight from the cycle after `socStrobe` through the `eocStrobe` cycle, and a write in the `eocStrobe` cycle itself counts.
- R7: The suppression is released by the next `socStrobe`, and the following end-of-conversion is compared against the rewritten bounds.
- R8: A bound write while no conversion is in flight does not suppress anything, and the new bound applies to the next end-of-conversion.
- R9: Writing either bound never deasserts an `outFlag` that is already set.
- R10: `irqPulse` rises only on the edge after a cycle with `eocStrobe` high. An out-of-window data word without `eocStrobe` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| socStrobe | input | 1 | Start-of-conversion strobe |
| eocStrobe | input | 1 | End-of-conversion strobe, qualifies `eocData` |
| eocData | input | DATA_W | Compensated conversion result |
| lowWrEn | input | 1 | Write enable for the low bound |
| lowWrData | input | DATA_W | New low bound |
| highWrEn | input | 1 | Write enable for the high bound |
| highWrData | input | DATA_W | New high bound |
| flagClr | input | 1 | Clears the sticky out-of-window flag |
| outFlag | output | 1 | Sticky out-of-window flag |
| irqPulse | output | 1 | One-cycle interrupt per qualifying result |

## Verification
The bench builds the block with the default DATA_W of 12. At that width the reset bounds 0 and 0xFFF are the true edges of the data range, so the bench can confirm that extreme words stay inside the reset window. A 12-bit width also lets the bench place results exactly on a bound, one step past it, and across a window that a mid-conversion rewrite has moved. These cases test that the old bounds still govern a masked conversion and that the new bounds take over after the next start strobe.

// File: rtl/win_watchdog_pkg.sv
package win_watchdog_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic compareEn;   // evaluate the window this cycle
    logic maskActive;  // end-of-conversion in this cycle is suppressed
  } ctrl_t;

endpackage

// File: rtl/win_watchdog_ctrl.sv
module win_watchdog_ctrl
  import win_watchdog_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  socStrobe,
  input  logic  eocStrobe,
  input  logic  thrWrite,
  output ctrl_t strobes
);

  logic convBusy;
  logic maskArmed;
  logic wrInFlight;

  // A write counts as in-flight once the start edge has passed
  assign wrInFlight = thrWrite & convBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convBusy <= 1'b0;
    end else if (socStrobe) begin
      convBusy <= 1'b1;
    end else if (eocStrobe) begin
      convBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskArmed <= 1'b0;
    end else if (socStrobe) begin
      maskArmed <= 1'b0;
    end else if (wrInFlight) begin
      maskArmed <= 1'b1;
    end
  end

  always_comb begin
    strobes.maskActive = maskArmed | wrInFlight;
    strobes.compareEn  = eocStrobe & ~strobes.maskActive;
  end

endmodule

// File: rtl/win_watchdog_dp.sv
module win_watchdog_dp
  import win_watchdog_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strobes,
  input  logic [DATA_W-1:0] eocData,
  input  logic              lowWrEn,
  input  logic [DATA_W-1:0] lowWrData,
  input  logic              highWrEn,
  input  logic [DATA_W-1:0] highWrData,
  input  logic              flagClr,
  output logic              outFlag,
  output logic              irqPulse
);

  localparam logic [DATA_W-1:0] LOW_RST  = '0;
  localparam logic [DATA_W-1:0] HIGH_RST = '1;

  logic [DATA_W-1:0] lowBound;
  logic [DATA_W-1:0] highBound;
  logic              outside;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowBound  <= LOW_RST;
      highBound <= HIGH_RST;
    end else begin
      if (lowWrEn)  lowBound  <= lowWrData;
      if (highWrEn) highBound <= highWrData;
    end
  end

  // Current bounds apply; a write this cycle lands after the compare
  assign outside = (eocData < lowBound) | (eocData > highBound);
  assign hit     = strobes.compareEn & outside;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      outFlag  <= 1'b0;
    end else begin
      irqPulse <= hit;
      if (hit) begin
        outFlag <= 1'b1;
      end else if (flagClr) begin
        outFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_watchdog_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              socStrobe,
  input  logic              eocStrobe,
  input  logic [DATA_W-1:0] eocData,
  input  logic              lowWrEn,
  input  logic [DATA_W-1:0] lowWrData,
  input  logic              highWrEn,
  input  logic [DATA_W-1:0] highWrData,
  input  logic              flagClr,
  output logic              outFlag,
  output logic              irqPulse
);

  ctrl_t strobes;

  win_watchdog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .socStrobe (socStrobe),
    .eocStrobe (eocStrobe),
    .thrWrite  (lowWrEn | highWrEn),
    .strobes   (strobes)
  );

  win_watchdog_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .eocData    (eocData),
    .lowWrEn    (lowWrEn),
    .lowWrData  (lowWrData),
    .highWrEn   (highWrEn),
    .highWrData (highWrData),
    .flagClr    (flagClr),
    .outFlag    (outFlag),
    .irqPulse   (irqPulse)
  );

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk
  import win_watchdog_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input logic  eocStrobe,
  input logic  lowWrEn,
  input logic  highWrEn,
  input logic  flagClr,
  input logic  outFlag,
  input logic  irqPulse,
  input ctrl_t strobes
);

  AST_IRQ_AFTER_EOC: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(eocStrobe)); // R10

  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> outFlag); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (outFlag && !flagClr) |=> outFlag); // R5

  AST_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (outFlag && (lowWrEn || highWrEn) && !flagClr) |=> outFlag); // R9

  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (eocStrobe && strobes.maskActive) |=> !irqPulse); // R6

  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outFlag) |-> irqPulse); // R2

endmodule

bind win_watchdog win_watchdog_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .eocStrobe (eocStrobe),
  .lowWrEn   (lowWrEn),
  .highWrEn  (highWrEn),
  .flagClr   (flagClr),
  .outFlag   (outFlag),
  .irqPulse  (irqPulse),
  .strobes   (strobes)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;

  localparam int DATA_W = 12;

  logic              clk = 1'b0;
  logic              rstN;
  logic              socStrobe, eocStrobe, lowWrEn, highWrEn, flagClr;
  logic [DATA_W-1:0] eocData, lowWrData, highWrData;
  logic              outFlag, irqPulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  win_watchdog #(.DATA_W(DATA_W)) uut (.*);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeBounds(input logic [DATA_W-1:0] lo, input logic [DATA_W-1:0] hi);
    lowWrEn = 1'b1; lowWrData = lo; highWrEn = 1'b1; highWrData = hi;
    @(negedge clk);
    lowWrEn = 1'b0; highWrEn = 1'b0;
  endtask

  // One conversion; flag result checked after the end strobe
  task automatic convert(input logic [DATA_W-1:0] d, input logic expIrq, input string req);
    socStrobe = 1'b1; @(negedge clk); socStrobe = 1'b0;
    idle(2);
    eocStrobe = 1'b1; eocData = d; @(negedge clk); eocStrobe = 1'b0;
    check(req, irqPulse, expIrq);
    @(negedge clk);
    check("R4", irqPulse, 1'b0);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    check("R5", outFlag, 1'b0);
  endtask

  task automatic testReset();
    check("R1", outFlag, 1'b0);
    check("R1", irqPulse, 1'b0);
    convert('0, 1'b0, "R1");
    convert('1, 1'b0, "R1");
    check("R1", outFlag, 1'b0);
  endtask

  task automatic testWindow();
    writeBounds(12'd100, 12'd200);          // idle write, R8
    convert(12'd99, 1'b1, "R2");
    check("R2", outFlag, 1'b1);
    clearFlag();
    convert(12'd100, 1'b0, "R3");
    convert(12'd200, 1'b0, "R3");
    check("R3", outFlag, 1'b0);
    convert(12'd201, 1'b1, "R2");
    clearFlag();
    writeBounds(12'd10, 12'd20);
    convert(12'd50, 1'b1, "R8");            // new bounds used at once
    clearFlag();
    writeBounds(12'd100, 12'd200);
  endtask

  task automatic testClearRace();
    convert(12'd5, 1'b1, "R2");
    socStrobe = 1'b1; @(negedge clk); socStrobe = 1'b0;
    eocStrobe = 1'b1; eocData = 12'd5; flagClr = 1'b1;
    @(negedge clk);
    eocStrobe = 1'b0; flagClr = 1'b0;
    check("R5", outFlag, 1'b1);
    idle(3);
    check("R5", outFlag, 1'b1);
    clearFlag();
  endtask

  task automatic testMask();
    // write mid-conversion: 250 would be out under old and new bounds
    socStrobe = 1'b1; @(negedge clk); socStrobe = 1'b0;
    @(negedge clk);
    lowWrEn = 1'b1; lowWrData = 12'd300; highWrEn = 1'b1; highWrData = 12'd400;
    @(negedge clk);
    lowWrEn = 1'b0; highWrEn = 1'b0;
    eocStrobe = 1'b1; eocData = 12'd250; @(negedge clk); eocStrobe = 1'b0;
    check("R6", irqPulse, 1'b0);
    check("R6", outFlag, 1'b0);
    convert(12'd250, 1'b1, "R7");           // below new low bound 300
    clearFlag();
    convert(12'd350, 1'b0, "R7");
    // write in the end-strobe cycle also masks
    socStrobe = 1'b1; @(negedge clk); socStrobe = 1'b0;
    @(negedge clk);
    eocStrobe = 1'b1; eocData = 12'd50;
    highWrEn = 1'b1; highWrData = 12'd500;
    @(negedge clk);
    eocStrobe = 1'b0; highWrEn = 1'b0;
    check("R6", irqPulse, 1'b0);
    check("R6", outFlag, 1'b0);
    convert(12'd50, 1'b1, "R7");
    clearFlag();
  endtask

  task automatic testWriteKeepsFlag();
    convert(12'd0, 1'b1, "R2");
    writeBounds('0, '1);
    idle(2);
    check("R9", outFlag, 1'b1);
    socStrobe = 1'b1; @(negedge clk); socStrobe = 1'b0;
    writeBounds(12'd1, 12'd2);              // in-flight write
    check("R9", outFlag, 1'b1);
    eocStrobe = 1'b1; eocData = 12'd1; @(negedge clk); eocStrobe = 1'b0;
    clearFlag();
  endtask

  task automatic testNoEoc();
    eocData = 12'd4000;                     // out of [1,2] but no strobe
    idle(4);
    check("R10", irqPulse, 1'b0);
    check("R10", outFlag, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; socStrobe = 0; eocStrobe = 0; lowWrEn = 0; highWrEn = 0;
    flagClr = 0; eocData = '0; lowWrData = '0; highWrData = '0;
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWindow();
    testClearRace();
    testMask();
    testWriteKeepsFlag();
    testNoEoc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule